// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserved / Store-Conditional

This block holds one storage reservation for an atomic read-modify-write sequence. An aligned load-reserved request records the granule address of its target and marks the reservation live. Two snoop paths can break it: a write seen from another bus master whose address falls in the reserved granule, and a separate "reservation broken" indication from outside snoop logic.

A store-conditional request is checked against the reservation. When the reservation is live, the store-conditional address matches the reserved granule, and no kill arrives in the same cycle, the write is passed to the bus. Otherwise the bus write is withheld and a failure flag goes back to the load/store unit. Every aligned store-conditional ends the reservation, whether it passes or fails. A misaligned load-reserved or store-conditional is never issued. It raises an alignment fault and leaves the reservation as it was. All results are registered and appear one clock after the request.

Top module: `resv_monitor`

## Requirements
- R1: While reset is held, and in the cycle after it is released, all outputs are 0. Reset makes the reservation not live, so a store-conditional to an address reserved before reset fails.
- R2: An aligned load-reserved request (address bits [GRAN_LSB-1:0] all zero) records address bits [ADDR_W-1:GRAN_LSB] and makes the reservation live. A later matching store-conditional then succeeds.
- R3: A later aligned load-reserved replaces the recorded address. A store-conditional to the earlier address fails, and one to the newest address succeeds.
- R4: A snoop write (snoopWrValid=1) whose address bits [ADDR_W-1:GRAN_LSB] equal the reserved ones clears the reservation, whatever its low bits are. A snoop write to a different granule leaves the reservation live.
- R5: resvBroken=1 clears the reservation. A load-reserved in the same cycle as resvBroken, or as a snoop write to its own granule, leaves the reservation not live.
- R6: A store-conditional with no live reservation gives busWrEn=0, scDone=1 and scFail=1 one cycle later.
- R7: A successful store-conditional gives busWrEn=1 with busWrAddr=scAddr and busWrData=scData, scDone=1 and scFail=0, one cycle after the request, for one cycle.
- R8: An aligned store-conditional clears the reservation whether it succeeds or fails.
- R9: A store-conditional with nonzero scAddr[GRAN_LSB-1:0] gives alignFault=1, scDone=0 and busWrEn=0 one cycle later, and leaves the reservation unchanged.
- R10: A load-reserved with nonzero lrAddr[GRAN_LSB-1:0] gives alignFault=1 one cycle later and does not alter the reservation.
- R11: An aligned store-conditional whose granule differs from the reserved one fails and clears the reservation.
- R12: A reservation kill (matching snoop write or resvBroken) in the same cycle as a store-conditional makes that store-conditional fail.
- R13: When lrReq and scReq are both 1, the load-reserved is ignored and only the store-conditional is handled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lrReq | input | 1 | Load-reserved request strobe |
| lrAddr | input | ADDR_W | Load-reserved byte address |
| scReq | input | 1 | Store-conditional request strobe |
| scAddr | input | ADDR_W | Store-conditional byte address |
| scData | input | DATA_W | Store-conditional write data |
| snoopWrValid | input | 1 | Write by another master observed |
| snoopWrAddr | input | ADDR_W | Address of the observed write |
| resvBroken | input | 1 | External indication that the reservation was broken |
| busWrEn | output | 1 | Store-conditional write issued to the bus |
| busWrAddr | output | ADDR_W | Bus write address |
| busWrData | output | DATA_W | Bus write data |
| scDone | output | 1 | Store-conditional status valid pulse |
| scFail | output | 1 | Store-conditional failed (with scDone) |
| alignFault | output | 1 | Misaligned request rejected |

## Verification
The bench builds the monitor with ADDR_W=16, DATA_W=8 and GRAN_LSB=2. The narrow address keeps the vectors short while the granule mask stays at word size. A snoop address such as 0x0403 can therefore hit a reservation at 0x0400 while 0x0500 misses it. Misaligned offsets of 1, 2 and 3 all fall inside the two ignored bits. The kill-versus-store race, the overwrite by a newer reservation, and a load-reserved arriving together with a store-conditional are all reached in single-cycle vectors. A reset in the middle of the run checks that the reservation does not survive reset.

// File: rtl/resv_pkg.sv
package resv_pkg;
  // Strobes from control to datapath, one cycle of effect each
  typedef struct packed {
    logic loadTag;    // capture load-reserved granule
    logic setValid;   // make reservation live
    logic clrValid;   // drop reservation
    logic captureWr;  // latch bus write address/data
  } resvStrobes_t;
endpackage

// File: rtl/resv_datapath.sv
module resv_datapath
  import resv_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int GRAN_LSB = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  resvStrobes_t      strobes,
  input  logic [ADDR_W-1:0] lrAddr,
  input  logic [ADDR_W-1:0] scAddr,
  input  logic [DATA_W-1:0] scData,
  input  logic [ADDR_W-1:0] snoopWrAddr,
  output logic              resvValid,
  output logic              scHit,
  output logic              snoopHit,
  output logic              lrSnoopHit,
  output logic [ADDR_W-1:0] busWrAddr,
  output logic [DATA_W-1:0] busWrData
);
  localparam int TAG_W = ADDR_W - GRAN_LSB;

  logic [TAG_W-1:0] resvTag;
  logic [TAG_W-1:0] lrTag, scTag, snoopTag;

  assign lrTag    = lrAddr[ADDR_W-1:GRAN_LSB];
  assign scTag    = scAddr[ADDR_W-1:GRAN_LSB];
  assign snoopTag = snoopWrAddr[ADDR_W-1:GRAN_LSB];

  assign scHit      = (scTag == resvTag);
  assign snoopHit   = (snoopTag == resvTag);
  assign lrSnoopHit = (snoopTag == lrTag);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resvTag   <= '0;
      resvValid <= 1'b0;
      busWrAddr <= '0;
      busWrData <= '0;
    end else begin
      if (strobes.loadTag) resvTag <= lrTag;
      if (strobes.setValid)      resvValid <= 1'b1;
      else if (strobes.clrValid) resvValid <= 1'b0;
      if (strobes.captureWr) begin
        busWrAddr <= scAddr;
        busWrData <= scData;
      end
    end
  end

  // R3: a recorded granule is the one of the newest accepted load-reserved
  a_r3_tag_replaced: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadTag |=> (resvTag == $past(lrTag)));

  // R2: set wins over clear when both are asked for
  a_r2_set_live: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setValid |=> resvValid);
endmodule

// File: rtl/resv_control.sv
module resv_control
  import resv_pkg::*;
#(
  parameter int GRAN_LSB = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                lrReq,
  input  logic [GRAN_LSB-1:0] lrLow,
  input  logic                scReq,
  input  logic [GRAN_LSB-1:0] scLow,
  input  logic                snoopWrValid,
  input  logic                resvBroken,
  input  logic                resvValid,
  input  logic                scHit,
  input  logic                snoopHit,
  input  logic                lrSnoopHit,
  output resvStrobes_t        strobes,
  output logic                busWrEn,
  output logic                scDone,
  output logic                scFail,
  output logic                alignFault
);
  logic lrAligned, scAligned;
  logic lrTake, lrGo, scGo, killOld, killNew, scPass;

  assign lrAligned = (lrLow == '0);
  assign scAligned = (scLow == '0);

  // store-conditional has precedence over a simultaneous load-reserved
  assign lrTake  = lrReq && !scReq;
  assign lrGo    = lrTake && lrAligned;
  assign scGo    = scReq && scAligned;

  assign killOld = resvBroken || (snoopWrValid && snoopHit);
  assign killNew = resvBroken || (snoopWrValid && lrSnoopHit);
  assign scPass  = scGo && resvValid && scHit && !killOld;

  always_comb begin
    strobes           = '0;
    strobes.loadTag   = lrGo;
    strobes.setValid  = lrGo && !killNew;
    strobes.clrValid  = killOld || scGo || (lrGo && killNew);
    strobes.captureWr = scPass;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busWrEn    <= 1'b0;
      scDone     <= 1'b0;
      scFail     <= 1'b0;
      alignFault <= 1'b0;
    end else begin
      busWrEn    <= scPass;
      scDone     <= scGo;
      scFail     <= scGo && !scPass;
      alignFault <= (scReq && !scAligned) || (lrTake && !lrAligned);
    end
  end

  // R6: a failed store-conditional never reaches the bus
  a_r6_fail_no_write: assert property (@(posedge clk) disable iff (!rstN)
    scFail |-> !busWrEn);

  // R7: a bus write always comes with a success status
  a_r7_write_is_success: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn |-> (scDone && !scFail));

  // R8: an aligned store-conditional ends the reservation
  a_r8_sc_clears: assert property (@(posedge clk) disable iff (!rstN)
    scGo |=> !resvValid);

  // R9: a misaligned store-conditional leaves the reservation alone
  a_r9_misaligned_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (scReq && !scAligned && !killOld) |=> $stable(resvValid));

  // R5: external break drops the reservation
  a_r5_broken_clears: assert property (@(posedge clk) disable iff (!rstN)
    resvBroken |=> !resvValid);

  // R12: a kill racing the store-conditional makes it fail
  a_r12_kill_fails: assert property (@(posedge clk) disable iff (!rstN)
    (scGo && killOld) |=> scFail);

  // R9: fault and status are never reported together
  a_r9_fault_excl: assert property (@(posedge clk) disable iff (!rstN)
    alignFault |-> (!scDone && !busWrEn));
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int GRAN_LSB = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lrReq,
  input  logic [ADDR_W-1:0] lrAddr,
  input  logic              scReq,
  input  logic [ADDR_W-1:0] scAddr,
  input  logic [DATA_W-1:0] scData,
  input  logic              snoopWrValid,
  input  logic [ADDR_W-1:0] snoopWrAddr,
  input  logic              resvBroken,
  output logic              busWrEn,
  output logic [ADDR_W-1:0] busWrAddr,
  output logic [DATA_W-1:0] busWrData,
  output logic              scDone,
  output logic              scFail,
  output logic              alignFault
);
  resvStrobes_t strobes;
  logic resvValid, scHit, snoopHit, lrSnoopHit;

  resv_control #(.GRAN_LSB(GRAN_LSB)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .lrReq        (lrReq),
    .lrLow        (lrAddr[GRAN_LSB-1:0]),
    .scReq        (scReq),
    .scLow        (scAddr[GRAN_LSB-1:0]),
    .snoopWrValid (snoopWrValid),
    .resvBroken   (resvBroken),
    .resvValid    (resvValid),
    .scHit        (scHit),
    .snoopHit     (snoopHit),
    .lrSnoopHit   (lrSnoopHit),
    .strobes      (strobes),
    .busWrEn      (busWrEn),
    .scDone       (scDone),
    .scFail       (scFail),
    .alignFault   (alignFault)
  );

  resv_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GRAN_LSB(GRAN_LSB)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .lrAddr      (lrAddr),
    .scAddr      (scAddr),
    .scData      (scData),
    .snoopWrAddr (snoopWrAddr),
    .resvValid   (resvValid),
    .scHit       (scHit),
    .snoopHit    (snoopHit),
    .lrSnoopHit  (lrSnoopHit),
    .busWrAddr   (busWrAddr),
    .busWrData   (busWrData)
  );
endmodule

// File: tb/sim_resv_monitor.sv
module sim_resv_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int NV = 35;

  typedef struct packed {
    logic          lr;
    logic          sc;
    logic          snp;
    logic          brk;
    logic [AW-1:0] lrA;
    logic [AW-1:0] scA;
    logic [AW-1:0] snA;
    logic [DW-1:0] dat;
    logic          eW;   // expected busWrEn
    logic          eD;   // expected scDone
    logic          eF;   // expected scFail
    logic          eA;   // expected alignFault
    logic [3:0]    req;
  } vec_t;

  // lr sc snp brk lrA scA snA dat | eW eD eF eA | req
  localparam vec_t VECS [NV] = '{
    '{0,0,0,0,16'h0000,16'h0000,16'h0000,8'h00, 0,0,0,0, 4'd1},  // R1 idle
    '{0,1,0,0,16'h0000,16'h0100,16'h0000,8'h11, 0,1,1,0, 4'd6},  // R6 no reservation
    '{1,0,0,0,16'h0100,16'h0000,16'h0000,8'h00, 0,0,0,0, 4'd2},  // R2 reserve
    '{0,1,0,0,16'h0000,16'h0100,16'h0000,8'hA5, 1,1,0,0, 4'd7},  // R7 success
    '{0,1,0,0,16'h0000,16'h0100,16'h0000,8'h22, 0,1,1,0, 4'd8},  // R8 cleared by success
    '{1,0,0,0,16'h0200,16'h0000,16'h0000,8'h00, 0,0,0,0, 4'd3},
    '{1,0,0,0,16'h0300,16'h0000,16'h0000,8'h00, 0,0,0,0, 4'd3},  // R3 overwrite
    '{0,1,0,0,16'h0000,16'h0200,16'h0000,8'h33, 0,1,1,0, 4'd3},  // R3 old addr fails
    '{1,0,0,0,16'h0300,16'h0000,16'h0000,8'h00, 0,0,0,0, 4'd3},
    '{0,1,0,0,16'h0000,16'h0300,16'h0000,8'h3C, 1,1,0,0, 4'd3},  // R3 newest succeeds
    '{1,0,0,0,16'h0400,16'h0000,16'h0000,8'h00, 0,0,0,0, 4'd4},
    '{0,0,1,0,16'h0000,16'h0000,16'h0500,8'h00, 0,0,0,0, 4'd4},  // R4 other granule
    '{0,1,0,0,16'h0000,16'h0400,16'h0000,8'h44, 1,1,0,0, 4'd4},  // R4 still live
    '{1,0,0,0,16'h0400,16'h0000,16'h0000,8'h00, 0,0,0,0, 4'd4},
    '{0,0,1,0,16'h0000,16'h0000,16'h0403,8'h00, 0,0,0,0, 4'd4},  // R4 same granule
    '{0,1,0,0,16'h0000,16'h0400,16'h0000,8'h45, 0,1,1,0, 4'd4},  // R4 killed
    '{1,0,0,0,16'h0600,16'h0000,16'h0000,8'h00, 0,0,0,0, 4'd5},
    '{0,0,0,1,16'h0000,16'h0000,16'h0000,8'h00, 0,0,0,0, 4'd5},  // R5 broken
    '{0,1,0,0,16'h0000,16'h0600,16'h0000,8'h66, 0,1,1,0, 4'd5},
    '{1,0,0,0,16'h0700,16'h0000,16'h0000,8'h00, 0,0,0,0, 4'd9},
    '{0,1,0,0,16'h0000,16'h0702,16'h0000,8'h77, 0,0,0,1, 4'd9},  // R9 misaligned sc
    '{0,1,0,0,16'h0000,16'h0700,16'h0000,8'h78, 1,1,0,0, 4'd9},  // R9 kept
    '{1,0,0,0,16'h0800,16'h0000,16'h0000,8'h00, 0,0,0,0, 4'd10},
    '{1,0,0,0,16'h0901,16'h0000,16'h0000,8'h00, 0,0,0,1, 4'd10}, // R10 misaligned lr
    '{0,1,0,0,16'h0000,16'h0800,16'h0000,8'h88, 1,1,0,0, 4'd10}, // R10 unchanged
    '{1,0,0,0,16'h0A00,16'h0000,16'h0000,8'h00, 0,0,0,0, 4'd11},
    '{0,1,0,0,16'h0000,16'h0B00,16'h0000,8'hAA, 0,1,1,0, 4'd11}, // R11 mismatch
    '{0,1,0,0,16'h0000,16'h0A00,16'h0000,8'hAB, 0,1,1,0, 4'd11}, // R11 cleared
    '{1,0,0,0,16'h0C00,16'h0000,16'h0000,8'h00, 0,0,0,0, 4'd12},
    '{0,1,1,0,16'h0000,16'h0C00,16'h0C00,8'hCC, 0,1,1,0, 4'd12}, // R12 snoop race
    '{1,0,0,0,16'h0D00,16'h0000,16'h0000,8'h00, 0,0,0,0, 4'd12},
    '{0,1,0,1,16'h0000,16'h0D00,16'h0000,8'hDD, 0,1,1,0, 4'd12}, // R12 broken race
    '{1,1,0,0,16'h0E00,16'h0E00,16'h0000,8'hEE, 0,1,1,0, 4'd13}, // R13 both
    '{0,1,0,0,16'h0000,16'h0E00,16'h0000,8'hEF, 0,1,1,0, 4'd13}, // R13 lr ignored
    '{1,0,0,1,16'h0F00,16'h0000,16'h0000,8'h00, 0,0,0,0, 4'd5}   // R5 lr with break
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lrReq = 1'b0, scReq = 1'b0, snoopWrValid = 1'b0, resvBroken = 1'b0;
  logic [AW-1:0] lrAddr = '0, scAddr = '0, snoopWrAddr = '0;
  logic [DW-1:0] scData = '0;
  logic busWrEn, scDone, scFail, alignFault;
  logic [AW-1:0] busWrAddr;
  logic [DW-1:0] busWrData;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  resv_monitor #(.ADDR_W(AW), .DATA_W(DW), .GRAN_LSB(2)) u0 (
    .clk(clk), .rstN(rstN),
    .lrReq(lrReq), .lrAddr(lrAddr),
    .scReq(scReq), .scAddr(scAddr), .scData(scData),
    .snoopWrValid(snoopWrValid), .snoopWrAddr(snoopWrAddr),
    .resvBroken(resvBroken),
    .busWrEn(busWrEn), .busWrAddr(busWrAddr), .busWrData(busWrData),
    .scDone(scDone), .scFail(scFail), .alignFault(alignFault)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkOuts(input string req, input logic w, input logic d,
                           input logic f, input logic a);
    check(req, "busWrEn", 32'(busWrEn), 32'(w));
    check(req, "scDone", 32'(scDone), 32'(d));
    check(req, "scFail", 32'(scFail), 32'(f));
    check(req, "alignFault", 32'(alignFault), 32'(a));
  endtask

  task automatic idleIn();
    lrReq = 0; scReq = 0; snoopWrValid = 0; resvBroken = 0;
    lrAddr = '0; scAddr = '0; snoopWrAddr = '0; scData = '0;
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    idleIn();
    repeat (3) @(negedge clk);
    checkOuts("R1", 0, 0, 0, 0);  // R1 outputs quiet in reset
    rstN = 1'b1;
    @(negedge clk);
    checkOuts("R1", 0, 0, 0, 0);  // R1 after release

    for (int i = 0; i < NV; i++) begin
      lrReq        = VECS[i].lr;
      scReq        = VECS[i].sc;
      snoopWrValid = VECS[i].snp;
      resvBroken   = VECS[i].brk;
      lrAddr       = VECS[i].lrA;
      scAddr       = VECS[i].scA;
      snoopWrAddr  = VECS[i].snA;
      scData       = VECS[i].dat;
      @(negedge clk);
      checkOuts($sformatf("R%0d vec%0d", VECS[i].req, i),
                VECS[i].eW, VECS[i].eD, VECS[i].eF, VECS[i].eA);
      if (VECS[i].eW) begin
        check($sformatf("R%0d vec%0d", VECS[i].req, i), "busWrAddr",
              32'(busWrAddr), 32'(VECS[i].scA));
        check($sformatf("R%0d vec%0d", VECS[i].req, i), "busWrData",
              32'(busWrData), 32'(VECS[i].dat));
      end
    end

    // R5: lr with break in the last vector left nothing live
    idleIn();
    scReq = 1; scAddr = 16'h0F00; scData = 8'hF0;
    @(negedge clk);
    checkOuts("R5 lr+break", 0, 1, 1, 0);

    // R7: status and write are one-cycle pulses
    idleIn();
    lrReq = 1; lrAddr = 16'h1234 & 16'hFFFC;
    @(negedge clk);
    idleIn();
    scReq = 1; scAddr = 16'h1234; scData = 8'h5A;
    @(negedge clk);
    checkOuts("R7 pulse", 1, 1, 0, 0);
    check("R7 pulse", "busWrAddr", 32'(busWrAddr), 32'h1234);
    idleIn();
    @(negedge clk);
    checkOuts("R7 pulse end", 0, 0, 0, 0);

    // R1: reservation does not survive reset
    lrReq = 1; lrAddr = 16'h2000;
    @(negedge clk);
    idleIn();
    rstN = 1'b0;
    @(negedge clk);
    checkOuts("R1 mid reset", 0, 0, 0, 0);
    rstN = 1'b1;
    scReq = 1; scAddr = 16'h2000; scData = 8'h20;
    @(negedge clk);
    checkOuts("R1 after reset", 0, 1, 1, 0);
    idleIn();
    @(negedge clk);

    finishRun();
  end
endmodule